// File: doc/BRIEF.md
# Oversampled asynchronous serial receiver

This block takes in frames sent one way over a single serial line and turns each frame into a parallel byte. The line sits at 1 between frames. A frame opens with a 0, carries eight data bits with the most significant bit first, adds a bit that makes the count of ones odd, and closes with a 1. The receiver runs on the system clock. A divider inside the block makes a one-cycle sampling enable at eight times the bit rate. With the default divide of 5000, a 24 MHz clock serves a 600 b/s line.

The line first passes through a two-flop synchronizer. A falling edge seen while idle starts the divider from zero. The block waits four enables to land in the middle of the start bit. After that it samples once every eight enables. The data bits are shifted in from the right, so the first bit received ends up in bit 7. The parity bit is folded into a running XOR, and then the stop bit is sampled.

At the end of a good frame the byte appears on `rx_data_o` in the same cycle as a one-cycle `rx_valid_o` pulse. There is no ready input and no back-pressure: a consumer must take the byte in the cycle `rx_valid_o` is high, and it can also read it afterwards because the byte stays on the output until the next good frame. A bad frame gives a one-cycle `rx_err_o` pulse instead. After either pulse the block returns to idle and waits for a new 1-to-0 transition.

Top module: `srx_receiver`

## Requirements
- R1: A synchronous active-high `rst` drives `rx_valid_o` and `rx_err_o` low and `rx_data_o` to 0. It abandons any frame in progress, and no pulse follows from that frame.
- R2: A well-formed frame produces exactly one `rx_valid_o` pulse and no error. `rx_data_o` then holds the byte, with the first data bit on the line in bit 7 and the last in bit 0 (for example 0,0,1,0,0,1,0,1,1,1,1 yields 8'h4B).
- R3: `rx_valid_o` and `rx_err_o` are each high for exactly one clock cycle per event.
- R4: If the line is back at 1 when the centre of the start bit is sampled (four sampling enables after the falling edge), the block gives one `rx_err_o` pulse and no `rx_valid_o`.
- R5: If the eight data bits plus the parity bit hold an even number of ones, the block gives one `rx_err_o` pulse and no `rx_valid_o`, and `rx_data_o` keeps its previous value.
- R6: If the stop bit is sampled as 0, the block gives one `rx_err_o` pulse and no `rx_valid_o`, and `rx_data_o` keeps its previous value.
- R7: After a frame ends, a line held at 0 starts no new frame. Reception resumes only after the line goes back to 1 and then falls again.
- R8: `rx_valid_o` and `rx_err_o` are never high in the same cycle, and `rx_data_o` changes only in a cycle where `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Serial line, asynchronous to `clk`, idles at 1 |
| rx_data_o | output | DATA_BITS | Last byte received without error |
| rx_valid_o | output | 1 | One-cycle pulse: a new byte is on `rx_data_o` |
| rx_err_o | output | 1 | One-cycle pulse: bad start, parity or stop |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges, and that `rx_i` only ever carries 0 or 1. They also assume that a consumer never has to stall the output, because the output has no ready signal. The bench meets these assumptions: it asserts reset before any frame is sent, and it changes the line only on falling clock edges. Every bit is held for a whole bit period, which is the divider value times eight. This keeps each sample well inside its bit, so the only errors the bench sees are the ones it creates on purpose: a short start glitch, a flipped parity bit, or a stop bit held at 0.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/srx_tick_gen.sv
// Sampling-enable divider, held at zero while not running so the first
// enable always comes exactly DIV cycles after a start edge.
module srx_tick_gen #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/srx_line_sync.sv
// Two-flop synchronizer plus falling-edge detector; reset to idle level.
module srx_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s = sync_q;
  assign fall   = prev_q & ~sync_q;
endmodule

// File: rtl/srx_frame_ctrl.sv
// Frame sequencer: centre-of-bit sampling, MSB-first shift, odd parity.
module srx_frame_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line_s,
  input  logic                 fall,
  output logic                 run,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 err_o
);
  localparam int SUBW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BCW  = $clog2(DATA_BITS + 1);
  localparam logic [SUBW-1:0] HALF_LAST = SUBW'(OVERSAMPLE / 2 - 1);
  localparam logic [SUBW-1:0] FULL_LAST = SUBW'(OVERSAMPLE - 1);
  localparam logic [BCW-1:0]  BIT_LAST  = BCW'(DATA_BITS - 1);

  rx_state_t            state;
  logic [SUBW-1:0]      sub;
  logic [BCW-1:0]       bitcnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 par;
  logic                 centre;

  assign run    = (state != ST_IDLE);
  assign centre = tick && (sub == FULL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sub     <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      par     <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (tick && state != ST_IDLE) sub <= sub + 1'b1;
      unique case (state)
        ST_IDLE: begin
          sub    <= '0;
          bitcnt <= '0;
          par    <= 1'b0;
          if (fall) state <= ST_START;
        end
        ST_START: begin
          if (tick && sub == HALF_LAST) begin
            sub <= '0;
            if (!line_s) begin
              state <= ST_DATA;
            end else begin
              err_o <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (centre) begin
            sub    <= '0;
            shreg  <= {shreg[DATA_BITS-2:0], line_s};
            par    <= par ^ line_s;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_LAST) state <= ST_PARITY;
          end
        end
        ST_PARITY: begin
          if (centre) begin
            sub   <= '0;
            par   <= par ^ line_s;
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (centre) begin
            state <= ST_IDLE;
            if (line_s && par) begin
              data_o  <= shreg;
              valid_o <= 1'b1;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
  parameter int CLK_DIV    = 5000,
  parameter int OVERSAMPLE = 8,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 rx_err_o
);
  logic line_s, fall, run, tick;

  srx_line_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (rx_i),
    .line_s (line_s),
    .fall   (fall)
  );

  srx_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  srx_frame_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .line_s  (line_s),
    .fall    (fall),
    .run     (run),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .err_o   (rx_err_o)
  );
endmodule

// File: rtl/srx_receiver_chk.sv
module srx_receiver_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] data,
  input logic                 valid,
  input logic                 err
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!valid && !err && data == '0));

  // R3
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R3
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R8
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid && err));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(data));
endmodule

bind srx_receiver srx_receiver_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .data  (rx_data_o),
  .valid (rx_valid_o),
  .err   (rx_err_o)
);

// File: tb/tb_srx_receiver.sv
`timescale 1ns/1ps
module tb_srx_receiver;
  localparam int DIV = 4;
  localparam int BIT = DIV * 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_err;

  int vectors = 0, miscompares = 0;
  int n_valid = 0, n_err = 0, n_wide = 0;
  logic prev_valid = 1'b0, prev_err = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  srx_receiver #(.CLK_DIV(DIV), .OVERSAMPLE(8), .DATA_BITS(8)) dut (
    .clk        (clk),
    .rst        (rst),
    .rx_i       (rx),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .rx_err_o   (rx_err)
  );

  always @(negedge clk) begin
    if (rx_valid) n_valid++;
    if (rx_err) n_err++;
    if ((rx_valid && prev_valid) || (rx_err && prev_err)) n_wide++;
    prev_valid = rx_valid;
    prev_err   = rx_err;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input logic stop);
    logic p;
    p = ~(^d) ^ flip_par;
    hold(1'b0, BIT);
    for (int i = 7; i >= 0; i--) hold(d[i], BIT);
    hold(p, BIT);
    hold(stop, BIT);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
    check(rx_err == 1'b0, "R1 err in reset", rx_err, 0);
    check(rx_data == 8'h00, "R1 data in reset", rx_data, 0);
    rst = 1'b0;
    hold(1'b1, 2 * BIT);
  endtask

  task automatic t_good(input logic [7:0] d);
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    send_frame(d, 1'b0, 1'b1);
    hold(1'b1, 2 * BIT);
    check(n_valid - v0 == 1, "R2 valid count", n_valid - v0, 1);
    check(n_err == e0, "R2 no error", n_err - e0, 0);
    check(rx_data == d, "R2 data MSB first", rx_data, d);
    check(n_wide == 0, "R3 pulse width", n_wide, 0);
  endtask

  task automatic t_bad_start;
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    hold(1'b0, 8);
    hold(1'b1, 4 * BIT);
    check(n_err - e0 == 1, "R4 error on start glitch", n_err - e0, 1);
    check(n_valid == v0, "R4 no valid", n_valid - v0, 0);
    check(n_wide == 0, "R3 pulse width", n_wide, 0);
  endtask

  task automatic t_bad_parity(input logic [7:0] d);
    int v0, e0;
    logic [7:0] keep;
    v0 = n_valid; e0 = n_err; keep = rx_data;
    send_frame(d, 1'b1, 1'b1);
    hold(1'b1, 2 * BIT);
    check(n_err - e0 == 1, "R5 error on even ones", n_err - e0, 1);
    check(n_valid == v0, "R5 no valid", n_valid - v0, 0);
    check(rx_data == keep, "R5 data kept", rx_data, keep);
  endtask

  task automatic t_bad_stop(input logic [7:0] d);
    int v0, e0;
    logic [7:0] keep;
    v0 = n_valid; e0 = n_err; keep = rx_data;
    send_frame(d, 1'b0, 1'b0);
    hold(1'b0, 2 * BIT);
    check(n_err - e0 == 1, "R6 error on low stop", n_err - e0, 1);
    check(n_valid == v0, "R6 no valid", n_valid - v0, 0);
    check(rx_data == keep, "R6 data kept", rx_data, keep);
    // R7: line stuck low must not start a frame
    hold(1'b0, 12 * BIT);
    check(n_err - e0 == 1, "R7 no pulse while low", n_err - e0, 1);
    check(n_valid == v0, "R7 no valid while low", n_valid - v0, 0);
    hold(1'b1, 2 * BIT);
    t_good(8'h3C);
  endtask

  task automatic t_mid_reset;
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    hold(1'b0, BIT);
    hold(1'b1, 3 * BIT);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rx_data == 8'h00 && !rx_valid && !rx_err, "R1 mid-frame reset", rx_data, 0);
    rst = 1'b0;
    hold(1'b1, 10 * BIT);
    check(n_valid == v0 && n_err == e0, "R1 frame abandoned",
          (n_valid - v0) + (n_err - e0), 0);
  endtask

  initial begin
    rst = 1'b1;
    rx  = 1'b1;
    t_reset();
    t_good(8'h4B);
    t_good(8'h00);
    t_good(8'hFF);
    t_good(8'hA5);
    t_good(8'h01);
    t_good(8'h80);
    t_bad_start();
    t_bad_parity(8'h5A);
    t_bad_parity(8'h07);
    t_bad_stop(8'hC3);
    t_mid_reset();
    t_good(8'h96);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule